// File: doc/BRIEF.md
# Ones Density Monitor and Enforcer

This block watches two serial T1 bit streams, one per direction, one bit per clock. It checks them against the line ones-density rules. A stream is in violation when a run of zeros grows past fifteen bits. It is also in violation when, for any N from 1 to 23, the most recent 8·(N+1) bits hold fewer than N ones. Each direction has its own sticky violation flag, which the host reads and clears with a one-cycle pulse.

On the transmit direction the block can also correct the stream. When correction is switched on and B8ZS line coding is not active, a zero is replaced by a one whenever sending it would break either rule at that bit. The transmit data always passes through one register, so it has one bit of latency whether correction is on or off. The transmit monitor watches the stream that actually leaves the block, after any correction.

Top module: `ones_density_guard`

## Requirements
- R1: While reset is high, and in the first cycle after it, `tx_data_out`, `tx_viol_flag` and `rx_viol_flag` are all 0.
- R2: When `tx_enforce_en` is 0, `tx_data_out` equals the `tx_data_in` value sampled at the previous rising clock edge.
- R3: A zero bit preceded by at least fifteen consecutive zero bits (all received since reset) sets the flag of its direction one cycle after that bit is sampled. Exactly fifteen zeros followed by a one do not set it.
- R4: For each N in 1..23, once at least 8·(N+1) bits have been seen since reset, a bit that closes an 8·(N+1)-bit window holding fewer than N ones sets the flag of its direction one cycle later.
- R5: Transmit and receive violations are reported separately, on `tx_viol_flag` and `rx_viol_flag`. A violation in one direction never sets the other direction's flag.
- R6: Each flag stays set until its clear input is high for a cycle, and then reads 0 in the next cycle. If a new violation is sampled in the same cycle as the clear, the flag stays 1.
- R7: When `tx_enforce_en` is 1 and `b8zs_on` is 0 continuously from reset, `tx_data_out` never violates either rule, for any input, and `tx_viol_flag` stays 0.
- R8: With correction active, an output bit is 1 when its input bit is 1, or when a 0 at that position would break either rule. Otherwise the input bit passes unchanged. An input 1 is never turned into a 0.
- R9: While `b8zs_on` is 1, correction is off and the transmit data passes unchanged, as in R2.
- R10: The transmit monitor judges the corrected output stream, not the raw input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one bit per cycle in each direction |
| rst | input | 1 | Synchronous active-high reset |
| tx_data_in | input | 1 | Transmit serial bit entering the block |
| tx_enforce_en | input | 1 | Enables ones insertion on transmit |
| b8zs_on | input | 1 | B8ZS coding active; suppresses ones insertion |
| clr_tx_flag | input | 1 | One-cycle clear of the transmit flag |
| rx_data_in | input | 1 | Receive serial bit to be monitored |
| clr_rx_flag | input | 1 | One-cycle clear of the receive flag |
| tx_data_out | output | 1 | Transmit bit after optional correction, one cycle late |
| tx_viol_flag | output | 1 | Sticky transmit density violation |
| rx_viol_flag | output | 1 | Sticky receive density violation |

## Verification
The receive stream is driven with several patterns:
- a long run of ones followed by exactly fifteen zeros and a one, which separates the zero-run limit from an off-by-one;
- sixteen zeros, which must trip the flag;
- a lone one every fifteen bits, which obeys the zero-run limit but starves the 24-bit window, so only the sliding-window rule can flag it.

On transmit, an all-zero input with correction on shows where ones get inserted. The same input with B8ZS active, or with correction off, shows pure passthrough and a raised flag. Sparse random data mixed with random toggling of correction, B8ZS and clears is compared bit for bit against a brute-force window count in the bench.

// File: rtl/odm_pkg.sv
package odm_pkg;
  // Largest N of the sliding rule and the longest legal zero run.
  localparam int ODM_MAX_N     = 23;
  localparam int ODM_RUN_LIMIT = 15;
endpackage

// File: rtl/odm_window.sv
// Density state for one serial stream: bit history, one running ones count
// per window length, and a zero-run counter. Reports whether appending a
// 0 or a 1 next would break a rule.
module odm_window #(
  parameter int MAX_N     = 23,
  parameter int RUN_LIMIT = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic shift_bit,
  output logic viol_if0,
  output logic viol_if1
);
  localparam int WIN_MAX = 8 * (MAX_N + 1);
  localparam int CW      = $clog2(WIN_MAX + 1);
  localparam int RW      = $clog2(RUN_LIMIT + 1);

  logic [WIN_MAX-1:0] hist_q;   // bit 0 is the most recent bit
  logic [CW-1:0]      fill_q;   // bits seen since reset, saturating
  logic [RW-1:0]      zrun_q;   // trailing zeros, saturating at RUN_LIMIT
  logic [MAX_N:1]     lo0, lo1;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      fill_q <= '0;
      zrun_q <= '0;
    end else begin
      hist_q <= {hist_q[WIN_MAX-2:0], shift_bit};
      if (fill_q != CW'(WIN_MAX)) fill_q <= fill_q + CW'(1);
      if (shift_bit)                       zrun_q <= '0;
      else if (zrun_q != RW'(RUN_LIMIT))   zrun_q <= zrun_q + RW'(1);
    end
  end

  // One window per N; history is zero after reset, so the departing bit
  // is 0 until the window has been filled once.
  for (genvar k = 1; k <= MAX_N; k++) begin : g_win
    localparam int              W      = 8 * (k + 1);
    localparam logic [CW-1:0]   NEED   = CW'(k);
    localparam logic [CW-1:0]   FULLAT = CW'(W - 1);
    logic [CW-1:0] ones_q;
    logic [CW-1:0] kept;
    logic          leave;
    logic          full_next;

    assign leave     = hist_q[W-1];
    assign kept      = ones_q - CW'(leave);
    assign full_next = (fill_q >= FULLAT);
    assign lo0[k]    = full_next && (kept < NEED);
    assign lo1[k]    = full_next && ((kept + CW'(1)) < NEED);

    always_ff @(posedge clk) begin
      if (rst) ones_q <= '0;
      else     ones_q <= kept + CW'(shift_bit);
    end
  end

  assign viol_if0 = (|lo0) || (zrun_q == RW'(RUN_LIMIT));
  assign viol_if1 = |lo1;
endmodule

// File: rtl/odm_enforcer.sv
// Forces the outgoing bit to 1 when a 0 would break a rule, then registers it.
module odm_enforcer (
  input  logic clk,
  input  logic rst,
  input  logic data_in,
  input  logic enforce_en,
  input  logic b8zs_on,
  input  logic must_one,
  output logic next_bit,
  output logic data_out
);
  assign next_bit = data_in | (enforce_en & ~b8zs_on & must_one);

  always_ff @(posedge clk) begin
    if (rst) data_out <= 1'b0;
    else     data_out <= next_bit;
  end
endmodule

// File: rtl/odm_flag.sv
// Sticky violation flag; a violation in the clear cycle keeps it set.
module odm_flag (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic viol_if0,
  input  logic viol_if1,
  input  logic clr,
  output logic flag_q
);
  logic viol;
  assign viol = bit_in ? viol_if1 : viol_if0;

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= viol | (flag_q & ~clr);
  end
endmodule

// File: rtl/ones_density_guard.sv
module ones_density_guard
  import odm_pkg::*;
#(
  parameter int MAX_N     = ODM_MAX_N,
  parameter int RUN_LIMIT = ODM_RUN_LIMIT
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_data_in,
  input  logic tx_enforce_en,
  input  logic b8zs_on,
  input  logic clr_tx_flag,
  input  logic rx_data_in,
  input  logic clr_rx_flag,
  output logic tx_data_out,
  output logic tx_viol_flag,
  output logic rx_viol_flag
);
  logic tx_next, tx_v0, tx_v1, rx_v0, rx_v1;

  // Transmit: correct, then monitor what is actually sent.
  odm_enforcer u_tx_enf (
    .clk(clk), .rst(rst), .data_in(tx_data_in), .enforce_en(tx_enforce_en),
    .b8zs_on(b8zs_on), .must_one(tx_v0), .next_bit(tx_next),
    .data_out(tx_data_out)
  );

  odm_window #(.MAX_N(MAX_N), .RUN_LIMIT(RUN_LIMIT)) u_tx_win (
    .clk(clk), .rst(rst), .shift_bit(tx_next),
    .viol_if0(tx_v0), .viol_if1(tx_v1)
  );

  odm_flag u_tx_flag (
    .clk(clk), .rst(rst), .bit_in(tx_next), .viol_if0(tx_v0),
    .viol_if1(tx_v1), .clr(clr_tx_flag), .flag_q(tx_viol_flag)
  );

  // Receive: monitor only.
  odm_window #(.MAX_N(MAX_N), .RUN_LIMIT(RUN_LIMIT)) u_rx_win (
    .clk(clk), .rst(rst), .shift_bit(rx_data_in),
    .viol_if0(rx_v0), .viol_if1(rx_v1)
  );

  odm_flag u_rx_flag (
    .clk(clk), .rst(rst), .bit_in(rx_data_in), .viol_if0(rx_v0),
    .viol_if1(rx_v1), .clr(clr_rx_flag), .flag_q(rx_viol_flag)
  );
endmodule

// File: rtl/odm_checker.sv
module odm_checker #(
  parameter int RUN_LIMIT = 15
) (
  input logic clk,
  input logic rst,
  input logic tx_data_in,
  input logic tx_enforce_en,
  input logic b8zs_on,
  input logic clr_tx_flag,
  input logic rx_data_in,
  input logic clr_rx_flag,
  input logic tx_data_out,
  input logic tx_viol_flag,
  input logic rx_viol_flag
);
  localparam int ZW = $clog2(RUN_LIMIT + 2);
  logic [ZW-1:0] rx_zr_q;

  always_ff @(posedge clk) begin
    if (rst)                               rx_zr_q <= '0;
    else if (rx_data_in)                   rx_zr_q <= '0;
    else if (rx_zr_q != ZW'(RUN_LIMIT))    rx_zr_q <= rx_zr_q + ZW'(1);
  end

  p_passthru_r2: assert property (@(posedge clk) disable iff (rst)
    !tx_enforce_en |=> (tx_data_out == $past(tx_data_in)));

  p_b8zs_bypass_r9: assert property (@(posedge clk) disable iff (rst)
    b8zs_on |=> (tx_data_out == $past(tx_data_in)));

  p_keeps_ones_r8: assert property (@(posedge clk) disable iff (rst)
    tx_data_in |=> tx_data_out);

  p_tx_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (tx_viol_flag && !clr_tx_flag) |=> tx_viol_flag);

  p_rx_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_viol_flag && !clr_rx_flag) |=> rx_viol_flag);

  p_zero_run_r3: assert property (@(posedge clk) disable iff (rst)
    ((rx_zr_q == ZW'(RUN_LIMIT)) && !rx_data_in) |=> rx_viol_flag);
endmodule

bind ones_density_guard odm_checker u_odm_chk (
  .clk(clk), .rst(rst), .tx_data_in(tx_data_in), .tx_enforce_en(tx_enforce_en),
  .b8zs_on(b8zs_on), .clr_tx_flag(clr_tx_flag), .rx_data_in(rx_data_in),
  .clr_rx_flag(clr_rx_flag), .tx_data_out(tx_data_out),
  .tx_viol_flag(tx_viol_flag), .rx_viol_flag(rx_viol_flag)
);

// File: tb/tb_ones_density_guard.sv
module tb_ones_density_guard;
  logic clk = 1'b0;
  logic rst, tx_data_in, tx_enforce_en, b8zs_on, clr_tx_flag;
  logic rx_data_in, clr_rx_flag;
  logic tx_data_out, tx_viol_flag, rx_viol_flag;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // Reference state: bit histories (bit 0 newest), lengths, expected flags.
  logic [191:0] th, rh;
  int tl, rl;
  logic ef_t, ef_r;

  always #5 clk = ~clk;

  ones_density_guard dut (
    .clk(clk), .rst(rst), .tx_data_in(tx_data_in), .tx_enforce_en(tx_enforce_en),
    .b8zs_on(b8zs_on), .clr_tx_flag(clr_tx_flag), .rx_data_in(rx_data_in),
    .clr_rx_flag(clr_rx_flag), .tx_data_out(tx_data_out),
    .tx_viol_flag(tx_viol_flag), .rx_viol_flag(rx_viol_flag)
  );

  // Brute-force rule check for appending bit b after history h of length len.
  function automatic logic viol_m(input logic [191:0] h, input int len, input logic b);
    logic v;
    int z;
    int ones;
    v = 1'b0;
    if (b == 1'b0 && len >= 15) begin
      z = 0;
      for (int i = 0; i < 15; i++) if (h[i]) z++;
      if (z == 0) v = 1'b1;
    end
    for (int n = 1; n <= 23; n++) begin
      if (len + 1 >= 8 * (n + 1)) begin
        ones = int'(b);
        for (int i = 0; i < 8 * (n + 1) - 1; i++) ones += int'(h[i]);
        if (ones < n) v = 1'b1;
      end
    end
    return v;
  endfunction

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; tx_data_in = 0; tx_enforce_en = 0; b8zs_on = 0;
    clr_tx_flag = 0; rx_data_in = 0; clr_rx_flag = 0;
    th = '0; rh = '0; tl = 0; rl = 0; ef_t = 0; ef_r = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(tx_data_out, 1'b0, "R1", "tx_data_out in reset");
    chk(tx_viol_flag, 1'b0, "R1", "tx flag in reset");
    chk(rx_viol_flag, 1'b0, "R1", "rx flag in reset");
    rst = 1'b0;
  endtask

  // Called at a falling edge: drive one bit per direction, predict, check.
  task automatic step(input logic tb, input logic en, input logic b8, input logic rb,
                      input logic ct, input logic cr, input string tag);
    logic y, vt, vr;
    tx_data_in = tb; tx_enforce_en = en; b8zs_on = b8;
    rx_data_in = rb; clr_tx_flag = ct; clr_rx_flag = cr;
    y  = tb | (en & ~b8 & viol_m(th, tl, 1'b0));
    vt = viol_m(th, tl, y);
    vr = viol_m(rh, rl, rb);
    ef_t = vt | (ef_t & ~ct);
    ef_r = vr | (ef_r & ~cr);
    th = {th[190:0], y};  if (tl < 192) tl++;
    rh = {rh[190:0], rb}; if (rl < 192) rl++;
    @(posedge clk);
    @(negedge clk);
    chk(tx_data_out, y, tag, "tx_data_out");
    chk(tx_viol_flag, ef_t, tag, "tx_viol_flag");
    chk(rx_viol_flag, ef_r, tag, "rx_viol_flag");
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();
    chk(tx_data_out, 1'b0, "R1", "tx_data_out after reset");
    chk(rx_viol_flag, 1'b0, "R1", "rx flag after reset");

    // R2: passthrough with dense random tx; rx long run of ones.
    for (int i = 0; i < 200; i++) step(1'($urandom), 0, 0, 1, 0, 0, "R2");
    // R3 boundary: fifteen zeros then a one must not flag.
    for (int i = 0; i < 15; i++) step(1'($urandom), 0, 0, 0, 0, 0, "R3");
    step(1, 0, 0, 1, 0, 0, "R3");
    chk(rx_viol_flag, 1'b0, "R3", "fifteen zeros no flag");
    for (int i = 0; i < 20; i++) step(1, 0, 0, 1, 0, 0, "R3");
    // R3: sixteen zeros flag; R5: tx stays clean.
    for (int i = 0; i < 16; i++) step(1, 0, 0, 0, 0, 0, "R5");
    chk(rx_viol_flag, 1'b1, "R3", "sixteen zeros flag");
    chk(tx_viol_flag, 1'b0, "R5", "tx flag separate");

    // R6: clear during ongoing violation keeps flag set.
    step(1, 0, 0, 0, 0, 1, "R6");
    chk(rx_viol_flag, 1'b1, "R6", "set wins over clear");
    for (int i = 0; i < 200; i++) step(1, 0, 0, 1, 0, 0, "R6");
    step(1, 0, 0, 1, 0, 1, "R6");
    chk(rx_viol_flag, 1'b0, "R6", "clear takes effect");
    for (int i = 0; i < 5; i++) step(1, 0, 0, 1, 0, 0, "R6");

    // R4: one every fifteen bits: zero runs legal, 24-bit window starved.
    for (int i = 0; i < 60; i++) step(1, 0, 0, (i % 15) == 14, 0, 0, "R4");
    chk(rx_viol_flag, 1'b1, "R4", "sliding window flag");

    // R7/R8: correction active from reset on all-zero and sparse input.
    @(negedge clk);
    do_reset();
    for (int i = 0; i < 300; i++) step(0, 1, 0, 1, 0, 0, "R7");
    for (int i = 0; i < 1000; i++) step(($urandom % 16) == 0, 1, 0, 1, 0, 0, "R8");
    chk(tx_viol_flag, 1'b0, "R7", "enforced stream clean");

    // R9/R10: B8ZS active disables correction; monitor sees raw zeros.
    for (int i = 0; i < 30; i++) step(0, 1, 1, 1, 0, 0, "R9");
    chk(tx_viol_flag, 1'b1, "R10", "output monitor flags");

    // Mixed random segments.
    for (int seg = 0; seg < 40; seg++) begin
      logic en, b8;
      int dens;
      en = 1'($urandom); b8 = (($urandom % 4) == 0);
      dens = 2 + int'($urandom % 20);
      for (int i = 0; i < 40; i++)
        step(($urandom % dens) == 0, en, b8, ($urandom % dens) == 0,
             ($urandom % 64) == 0, ($urandom % 64) == 0, "R4");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule